// File: doc/BRIEF.md
# Multi-Lane Serial Transmit Shifter

This block sends a software-prepared word out on one, two or four output pins. On each shift step, the next group of bits from the bottom of the word goes onto the active pins. Because the word is prepared in software, one word can carry several parallel streams, with the bits of each stream set one lane apart. For example, a clock on pin 0 and data on pin 1 gives clocked serial output. The block itself has no protocol logic, so a Manchester stream is just pair-replicated data XORed with an alternating mask and sent on a single lane.

Each word is loaded together with its own lane count, length and step period. A one-word holding register lets software queue the next word while the current one is still shifting, so back-to-back words leave no idle cycle on the pins. There is also a combinational helper that duplicates every bit of its input into an adjacent pair, which software uses when it prepares clocked or Manchester patterns.

Top module: `lane_shift_tx`

## Requirements
- R1: After reset, `pins` is 0, `busy` is 0 and `ld_ready` is 1.
- R2: `ld_lanes` selects the lane count: 0 means 1 lane, 1 means 2 lanes, and 2 or 3 mean 4 lanes. Pins above the active lane count are driven 0.
- R3: Step k, counted from 0, puts word bit k*L+j on `pins[j]` for each active lane j, where L is the lane count. The lowest bits go out first.
- R4: A word takes ceil(len/L) steps. A `ld_len` of 0 or greater than W counts as W.
- R5: Each step's group is held on the pins for exactly `ld_div` clock cycles. A `ld_div` of 0 counts as 1.
- R6: A word accepted while idle shows its first group in the cycle after the accepting edge. `busy` is 1 from that cycle until its last step has been held for its full period.
- R7: There is a one-word holding register, and `ld_ready` is 1 exactly when it is empty. A queued word's first group follows the previous word's last group with no gap. Lane count, length and period are captured per word.
- R8: While idle, `pins` keeps the last group that was sent.
- R9: `rep_out[2i]` and `rep_out[2i+1]` both equal `rep_in[i]`, combinationally.
- R10: `ld_valid` asserted while `ld_ready` is 0 has no effect: the word is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Load can be accepted |
| ld_word | input | W | Word to send |
| ld_lanes | input | 2 | Lane-count select |
| ld_len | input | $clog2(W+1) | Word length in bits |
| ld_div | input | DW | Clocks per step |
| busy | output | 1 | Shifting in progress |
| pins | output | 4 | Serial lane outputs |
| rep_in | input | W/2 | Replication helper input |
| rep_out | output | W | Pair-replicated output |

## Verification
The assertions check four things on every cycle. An accepted load always leads to `busy` on the next cycle. A full holding register only occurs while busy. The pins do not move when the block is idle and nothing is offered. The pins do not move on the cycle that `busy` falls. Bit-to-lane ordering, step counts, per-step hold length, gapless chaining of a queued word and the discarding of refused loads can only be shown by the bench's expected-output stream. That stream is built from each accepted word under random and directed settings.

// File: rtl/lane_shift_tx.sv
module lane_shift_tx #(
  parameter int W  = 32,
  parameter int DW = 8,
  localparam int LW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [W-1:0]  ld_word,
  input  logic [1:0]    ld_lanes,
  input  logic [LW-1:0] ld_len,
  input  logic [DW-1:0] ld_div,
  output logic          busy,
  output logic [3:0]    pins,
  input  logic [W/2-1:0] rep_in,
  output logic [W-1:0]  rep_out
);

  function automatic logic [3:0] grp(input logic [W-1:0] w, input logic [1:0] lg);
    case (lg)
      2'd0:    grp = {3'b000, w[0]};
      2'd1:    grp = {2'b00, w[1:0]};
      default: grp = w[3:0];
    endcase
  endfunction

  // lane select -> log2 of lane count, effective length, step count, period
  logic [1:0]    in_lg;
  logic [LW:0]   in_len;
  logic [LW-1:0] in_steps;
  logic [DW-1:0] in_div;
  logic [LW:0]   rnd;

  assign in_lg  = (ld_lanes == 2'd0) ? 2'd0 : (ld_lanes == 2'd1) ? 2'd1 : 2'd2;
  assign in_len = (ld_len == '0 || {1'b0, ld_len} > (LW+1)'(W)) ? (LW+1)'(W) : {1'b0, ld_len};
  assign rnd    = in_len + (LW+1)'((1 << in_lg) - 1);
  assign in_steps = LW'(rnd >> in_lg);
  assign in_div = (ld_div == '0) ? DW'(1) : ld_div;

  // holding register
  logic          hold_v;
  logic [W-1:0]  hold_w;
  logic [1:0]    hold_lg;
  logic [LW-1:0] hold_steps;
  logic [DW-1:0] hold_div;

  // shifter state
  logic [W-1:0]  sh;
  logic [1:0]    cur_lg;
  logic [LW-1:0] steps_left;
  logic [DW-1:0] cur_div, div_cnt;
  logic [3:0]    pins_q;
  logic          busy_q;

  logic ld_fire, step_end, last, take, start;
  logic [W-1:0]  src_w;
  logic [1:0]    src_lg;
  logic [LW-1:0] src_steps;
  logic [DW-1:0] src_div;

  assign ld_ready = !hold_v;
  assign ld_fire  = ld_valid && ld_ready;
  assign step_end = busy_q && (div_cnt == '0);
  assign last     = step_end && (steps_left == LW'(1));
  assign take     = !busy_q || last;
  assign start    = take && (hold_v || ld_fire);

  assign src_w     = hold_v ? hold_w     : ld_word;
  assign src_lg    = hold_v ? hold_lg    : in_lg;
  assign src_steps = hold_v ? hold_steps : in_steps;
  assign src_div   = hold_v ? hold_div   : in_div;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v     <= 1'b0;
      hold_w     <= '0;
      hold_lg    <= '0;
      hold_steps <= '0;
      hold_div   <= '0;
    end else if (hold_v) begin
      if (start) hold_v <= 1'b0;
    end else if (ld_fire && !take) begin
      hold_v     <= 1'b1;
      hold_w     <= ld_word;
      hold_lg    <= in_lg;
      hold_steps <= in_steps;
      hold_div   <= in_div;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh         <= '0;
      cur_lg     <= '0;
      steps_left <= '0;
      cur_div    <= '0;
      div_cnt    <= '0;
      pins_q     <= '0;
      busy_q     <= 1'b0;
    end else if (start) begin
      pins_q     <= grp(src_w, src_lg);
      sh         <= src_w >> (1 << src_lg);
      cur_lg     <= src_lg;
      steps_left <= src_steps;
      cur_div    <= src_div;
      div_cnt    <= src_div - DW'(1);
      busy_q     <= 1'b1;
    end else if (last) begin
      busy_q <= 1'b0;
    end else if (step_end) begin
      pins_q     <= grp(sh, cur_lg);
      sh         <= sh >> (1 << cur_lg);
      steps_left <= steps_left - LW'(1);
      div_cnt    <= cur_div - DW'(1);
    end else if (busy_q) begin
      div_cnt <= div_cnt - DW'(1);
    end
  end

  assign busy = busy_q;
  assign pins = pins_q;

  for (genvar i = 0; i < W/2; i++) begin : g_rep
    assign rep_out[2*i+1:2*i] = {2{rep_in[i]}};
  end

endmodule

// File: rtl/lane_shift_tx_chk.sv
module lane_shift_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_valid,
  input logic       ld_ready,
  input logic       busy,
  input logic [3:0] pins
);

  a_r6_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> busy);

  a_r7_full_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ready |-> busy);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ld_valid) |=> $stable(pins));

  a_r8_end_keeps_pins: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $stable(pins));

endmodule

bind lane_shift_tx lane_shift_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .busy(busy), .pins(pins)
);

// File: tb/tb_lane_shift_tx.sv
module tb_lane_shift_tx;
  localparam int W  = 32;
  localparam int DW = 8;
  localparam int LW = $clog2(W + 1);

  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, ld_ready, busy;
  logic [W-1:0] ld_word = '0;
  logic [1:0] ld_lanes = '0;
  logic [LW-1:0] ld_len = '0;
  logic [DW-1:0] ld_div = '0;
  logic [3:0] pins;
  logic [W/2-1:0] rep_in = '0;
  logic [W-1:0] rep_out;

  int n_chk = 0, n_bad = 0;
  logic [3:0] expq[$];
  logic [3:0] last_exp = 4'h0;
  logic mon_on = 0;

  always #2 clk = ~clk;

  lane_shift_tx #(.W(W), .DW(DW)) dut (.*);

  function automatic logic [W-1:0] rep_model(input logic [W/2-1:0] d);
    logic [W-1:0] r;
    for (int i = 0; i < W/2; i++) begin
      r[2*i] = d[i];
      r[2*i+1] = d[i];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected pin stream for one word (R2, R3, R4, R5)
  task automatic push_exp(input logic [W-1:0] w, input logic [1:0] ls, input int len, input int dv);
    int L = (ls == 0) ? 1 : (ls == 1) ? 2 : 4;
    int le = (len == 0 || len > W) ? W : len;
    int st = (le + L - 1) / L;
    int de = (dv == 0) ? 1 : dv;
    for (int k = 0; k < st; k++) begin
      logic [3:0] g = 4'((w >> (k * L)) & ((1 << L) - 1));
      for (int d = 0; d < de; d++) expq.push_back(g);
    end
  endtask

  task automatic send(input logic [W-1:0] w, input logic [1:0] ls, input int len, input int dv);
    @(negedge clk);
    while (!ld_ready) @(negedge clk);
    ld_valid = 1; ld_word = w; ld_lanes = ls; ld_len = LW'(len); ld_div = DW'(dv);
    push_exp(w, ls, len, dv);
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic drain;
    @(negedge clk);
    while (busy || ld_valid || !ld_ready) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: sample just after each rising edge
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      if (busy) begin
        if (expq.size() == 0) check(0, "R4 extra step while busy", W'(pins), 0);
        else begin
          last_exp = expq.pop_front();
          check(pins == last_exp, "R3 pin group", W'(pins), W'(last_exp));
        end
      end else begin
        check(pins == last_exp, "R8 idle pins", W'(pins), W'(last_exp));
        if (expq.size() != 0) check(0, "R6 busy ended early", W'(expq.size()), 0);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(pins == 0, "R1 pins", W'(pins), 0);
    check(busy == 0, "R1 busy", W'(busy), 0);
    check(ld_ready == 1, "R1 ld_ready", W'(ld_ready), 1);
    mon_on = 1;

    // R9 helper
    for (int i = 0; i < 6; i++) begin
      rep_in = (i == 0) ? '0 : (i == 1) ? '1 : (W/2)'($urandom);
      #1;
      check(rep_out == rep_model(rep_in), "R9 replication", rep_out, rep_model(rep_in));
    end

    // R2/R3 lane modes incl. select value 3, single-step hold
    send(32'hDEADBEEF, 2'd0, 8, 1);
    send(32'h12345678, 2'd1, 16, 2);
    send(32'h9ABCDEF0, 2'd2, 32, 3);
    send(32'h0F1E2D3C, 2'd3, 12, 0);  // R5 div 0 as 1, R2 code 3
    drain;

    // R4 rounding and length 0 / above W
    send(32'hA5A5A5A5, 2'd2, 5, 1);
    send(32'h5A5A5A5A, 2'd1, 0, 1);
    send(32'hFFFF0000, 2'd0, 33, 1);
    drain;

    // clocked byte on 2 lanes: lane0 clock, lane1 data, bit 7 first
    begin
      logic [7:0] b = 8'hB4;
      logic [W-1:0] w = '0;
      for (int j = 0; j < 16; j++) begin
        w[2*j]   = (j % 2 == 0);
        w[2*j+1] = b[7 - j/2];
      end
      send(w, 2'd1, 32, 2);
    end
    // Manchester on one lane via helper
    rep_in = 16'hC3A5;
    #1;
    send(rep_out ^ 32'h55555555, 2'd0, 32, 1);
    drain;

    // R7 gapless queue, R10 refused load
    send(32'h11112222, 2'd2, 8, 20);
    send(32'h33334444, 2'd1, 8, 3);
    @(negedge clk);
    check(ld_ready == 0, "R7 holding full", W'(ld_ready), 0);
    ld_valid = 1; ld_word = 32'hBADBADBA; ld_lanes = 2'd0; ld_len = 6'd4; ld_div = 8'd1;
    @(negedge clk);
    check(ld_ready == 0, "R10 refused load stays out", W'(ld_ready), 0);
    ld_valid = 0;
    drain;

    // R6 latency from idle
    send(32'h0000000F, 2'd2, 4, 4);
    check(busy == 1, "R6 busy after accept", W'(busy), 1);
    drain;

    // random mix
    for (int n = 0; n < 60; n++) begin
      send($urandom, 2'($urandom), int'($urandom % (W + 2)), int'($urandom % 6));
      if ($urandom % 3 == 0) repeat ($urandom % 4) @(negedge clk);
    end
    drain;
    check(expq.size() == 0, "R4 stream complete", W'(expq.size()), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule